// File: doc/BRIEF.md
# Table-Driven Motor Speed Servo

This block regulates motor speed from a tachometer without any analog loop. An 8-bit position counter advances by one on every reference clock. When a rising tachometer edge arrives, the counter is reloaded from a 256-entry, 8-bit programmable table. The table is indexed by the count reached at that moment, so the reload value encodes the speed error correction. The same table entry also supplies a drive bit. That bit, registered, is the motor PWM output. When the motor is slow, the counter climbs further between pulses and reaches entries whose drive bit is set. The on-time therefore grows with load without any extra logic.

The table can be rewritten through a single write port. This lets the loop gain and lock range, the duty-cycle profile over the count, and the start-up torque be tuned. Examples of gain choices are halving, a third or a quarter of the error, or subtracting a small constant from it. Reset loads a default profile. In that profile the loop settles near count 64, and every entry from 128 upward drives the motor fully on. If no tachometer pulse arrives, the counter stops at its top value, so a stalled motor keeps full drive.

Top module: `tach_servo`

## Requirements
- R1: While rst_n is low, count_out is 0 and pwm_out is 0.
- R2: On each clock with no reload and count_out below 255, count_out increases by exactly 1.
- R3: With no reload, count_out held at 255 stays at 255 (no wrap to 0).
- R4: tach_in is passed through two synchronizing flops. A rising edge that is first sampled high at clock edge k causes exactly one reload, at clock edge k+2. Keeping tach_in high causes no further reloads.
- R5: A reload sets count_out to bits [6:0] of the table entry addressed by the count held just before that edge, with bit 7 of count_out cleared.
- R6: pwm_out after each clock edge equals bit 7 of the table entry addressed by count_out just before that edge.
- R7: When wr_en is high at a clock edge, entry wr_addr holds wr_data from that edge on. Every later reload or PWM lookup of that address uses the new value.
- R8: After reset, entry a holds a drive bit (bit 7) of 1 exactly when a >= 64. Its reload value (bits [6:0]) is min((a+64)/2, 127).
- R9: After reset, every entry with address >= 128 has its drive bit set, so a stalled counter at 255 gives pwm_out = 1.
- R10: If a write and a reload happen at the same clock edge and the write targets the entry being read, the reload uses the entry's content from before that edge.
- R11: A falling edge of tach_in causes no reload; counting continues as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Raw tachometer pulse, asynchronous |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table entry to write |
| wr_data | input | 8 | Entry value: bit 7 drive, bits [6:0] reload |
| pwm_out | output | 1 | Registered motor drive |
| count_out | output | 8 | Current position counter |

## Verification
The reload lookup and the table write port can act on the same entry in the same clock. The bench steers this case deliberately. It tracks its own cycle model of the synchronizer, waits for the cycle where a reload is due, and then writes new contents to the address equal to the current count. The counter value after that edge must match the entry's old reload value. Random writes mixed with random tachometer periods and pulse widths also produce further collisions. The bench checks each of these against its cycle model, which applies a write only after the lookup.

// File: rtl/tsv_pkg.sv
package tsv_pkg;

   typedef enum logic [1:0] {
      ACT_INC  = 2'd0,
      ACT_HOLD = 2'd1,
      ACT_LOAD = 2'd2
   } cnt_act_e;

   // Default profile: drive on from the center upward, reload halves
   // the distance to the center, clamped to the reload field range.
   function automatic int default_entry(int addr, int cnt_w, int center);
      int pw;
      int pmax;
      int pre;
      int drv;
      pw   = cnt_w - 1;
      pmax = (1 << pw) - 1;
      pre  = (addr + center) / 2;
      if (pre > pmax) pre = pmax;
      drv  = (addr >= center) ? 1 : 0;
      return (drv << pw) | pre;
   endfunction

endpackage

// File: rtl/tsv_tach_edge.sv
module tsv_tach_edge #(
   parameter int SYNC_STAGES = 2,
   parameter bit RISING      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tach_in,
   output logic load_o
);

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("tsv_tach_edge: SYNC_STAGES must be 2..4");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   hist_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         hist_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], tach_in};
         hist_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign synced = sync_q[SYNC_STAGES-1];

   if (RISING) begin : g_rise
      assign load_o = synced & ~hist_q;
   end else begin : g_fall
      assign load_o = ~synced & hist_q;
   end

   // R4: one reload per pulse
   a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o);

endmodule

// File: rtl/tsv_counter.sv
module tsv_counter
   import tsv_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-2:0] preset_i,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   cnt_act_e         act;

   if (SATURATE) begin : g_sat
      always_comb begin
         if (load_i)           act = ACT_LOAD;
         else if (cnt_q == TOP) act = ACT_HOLD;
         else                  act = ACT_INC;
      end
   end else begin : g_wrap
      always_comb begin
         if (load_i) act = ACT_LOAD;
         else        act = ACT_INC;
      end
   end

   always_comb begin
      unique case (act)
         ACT_LOAD: cnt_d = {1'b0, preset_i};
         ACT_HOLD: cnt_d = cnt_q;
         default:  cnt_d = cnt_q + 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count_o = cnt_q;

   // R2: plain increment below the top
   a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);

   // R3: stays at the top value
   if (SATURATE) begin : g_sat_chk
      a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
         (!load_i && cnt_q == TOP) |=> cnt_q == TOP);
   end

   // R5: reload takes the preset field
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_q == {1'b0, $past(preset_i)});

endmodule

// File: rtl/tsv_table.sv
module tsv_table
   import tsv_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int CENTER = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [CNT_W-1:0] rd_addr,
   output logic [CNT_W-1:0] rd_data
);

   localparam int DEPTH = 1 << CNT_W;

   logic [CNT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= CNT_W'(default_entry(i, CNT_W, CENTER));
         end
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   // Lookup sees contents before any write at the same edge (R10)
   assign rd_data = mem[rd_addr];

   // R7: write lands at the next edge
   a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/tach_servo.sv
module tach_servo
   import tsv_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int CENTER      = 64,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tach_in,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic [CNT_W-1:0] count_out
);

   localparam int DEPTH    = 1 << CNT_W;
   localparam int PRESET_W = CNT_W - 1;

   if (CNT_W < 3 || CNT_W > 8) begin : g_bad_width
      $error("tach_servo: CNT_W must be 3..8");
   end
   if (CENTER <= 0 || CENTER >= DEPTH / 2) begin : g_bad_center
      $error("tach_servo: CENTER must lie in the lower half");
   end

   logic                load;
   logic [CNT_W-1:0]    count;
   logic [CNT_W-1:0]    entry;
   logic                pwm_q;

   tsv_tach_edge #(
      .SYNC_STAGES(SYNC_STAGES),
      .RISING     (1'b1)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tach_in(tach_in),
      .load_o (load)
   );

   tsv_table #(
      .CNT_W (CNT_W),
      .CENTER(CENTER)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(count),
      .rd_data(entry)
   );

   tsv_counter #(
      .CNT_W   (CNT_W),
      .SATURATE(SATURATE)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .preset_i(entry[PRESET_W-1:0]),
      .count_o (count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= entry[CNT_W-1];
   end

   assign pwm_out   = pwm_q;
   assign count_out = count;

   // R6: drive follows the entry addressed one cycle earlier
   a_r6_pwm_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pwm_out == $past(entry[CNT_W-1]));

   // R1: reset values
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_state: assert (count_out == '0 && pwm_out == 1'b0);
      end
   end

endmodule

// File: tb/sim_tach_servo.sv
module sim_tach_servo;
   import tsv_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tach_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm_out;
   logic [7:0] count_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tach_servo u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tach_in  (tach_in),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pwm_out  (pwm_out),
      .count_out(count_out)
   );

   // ---- bench model built from the requirements ----
   logic [7:0] m_mem [256];
   logic [7:0] m_cnt;
   logic       m_pwm;
   logic       m_s1, m_s2, m_s3;
   string      m_tag;

   function automatic logic [7:0] dflt(int a);
      int p;
      p = (a + 64) / 2;
      if (p > 127) p = 127;
      return 8'(((a >= 64) ? 128 : 0) + p);   // R8
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) m_mem[i] <= dflt(i);
         m_cnt <= '0;
         m_pwm <= 1'b0;
         m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
         m_tag <= "R1";
      end else begin
         if (m_s2 && !m_s3) begin
            m_cnt <= {1'b0, m_mem[m_cnt][6:0]};
            m_tag <= "R5";
         end else if (m_cnt == 8'hFF) begin
            m_tag <= "R3";
         end else begin
            m_cnt <= m_cnt + 8'd1;
            m_tag <= "R2";
         end
         m_pwm <= m_mem[m_cnt][7];
         if (wr_en) m_mem[wr_addr] <= wr_data;  // after lookup: R10
         m_s1 <= tach_in; m_s2 <= m_s1; m_s3 <= m_s2;
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // continuous comparison, away from the active edge
   bit mon_on = 1'b0;
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         chk(count_out == m_cnt, m_tag, count_out, m_cnt);
         chk(pwm_out == m_pwm, "R6", pwm_out, m_pwm);
      end
   end

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(int hi, int lo);
      tach_in = 1'b1; cyc(hi);
      tach_in = 1'b0; cyc(lo);
   endtask

   initial begin
      int seed;
      logic [7:0] old_e;
      logic [7:0] c0;
      int loads;
      seed = 1234;
      void'($urandom(seed));

      // R1: reset state
      cyc(3);
      chk(count_out == 8'd0, "R1", count_out, 0);
      chk(pwm_out == 1'b0, "R1", pwm_out, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R2, R3, R8, R9: free run to saturation
      cyc(10);
      chk(count_out == 8'd10, "R2", count_out, 10);
      cyc(300);
      chk(count_out == 8'hFF, "R3", count_out, 255);
      chk(pwm_out == 1'b1, "R9", pwm_out, 1);

      // R4, R5, R8: rising edge at saturation -> default entry 255 reloads 127
      tach_in = 1'b1;
      cyc(1);
      cyc(1);
      chk(count_out == 8'hFF, "R4", count_out, 255);
      cyc(1);
      chk(count_out == 8'd127, "R8", count_out, 127);
      // R4: held high, no second reload
      cyc(20);
      chk(count_out == 8'd147, "R4", count_out, 147);
      // R11: falling edge, no reload
      c0 = count_out;
      tach_in = 1'b0;
      cyc(5);
      chk(count_out == c0 + 8'd5, "R11", count_out, c0 + 5);

      // locking with periodic pulses near 128 cycles
      for (int k = 0; k < 30; k++) pulse(8, 120);

      // random periods and widths with random writes
      for (int k = 0; k < 200; k++) begin
         int hi, lo;
         hi = 2 + ($urandom % 20);
         lo = 60 + ($urandom % 200);
         tach_in = 1'b1;
         for (int j = 0; j < hi + lo; j++) begin
            if (j == hi) tach_in = 1'b0;
            wr_en = ($urandom % 8) == 0;
            wr_addr = 8'($urandom);
            wr_data = 8'($urandom);
            @(negedge clk);
         end
         wr_en = 1'b0;
      end

      // R7: write entry, then reload from it
      cyc(300);
      wr_en = 1'b1; wr_addr = 8'hFF; wr_data = 8'h15;
      cyc(1);
      wr_en = 1'b0;
      tach_in = 1'b1;
      cyc(3);
      chk(count_out == 8'h15, "R7", count_out, 8'h15);
      tach_in = 1'b0;
      cyc(4);

      // R10: collisions of reload and write on the addressed entry
      for (int k = 0; k < 20; k++) begin
         cyc(30 + ($urandom % 40));
         tach_in = 1'b1;
         loads = 0;
         while (!(m_s2 && !m_s3)) begin
            cyc(1);
            loads++;
         end
         old_e = m_mem[m_cnt];
         wr_en = 1'b1;
         wr_addr = count_out;
         wr_data = ~old_e;
         cyc(1);
         wr_en = 1'b0;
         chk(count_out == {1'b0, old_e[6:0]}, "R10", count_out, {1'b0, old_e[6:0]});
         tach_in = 1'b0;
         cyc(4);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule